// File: doc/BRIEF.md
# Indirect Per-Channel Configuration Word Access

This block gives a host processor access, one 16-bit word at a time, to a configuration memory that holds three 32-bit dwords for each of 256 channels. The host first loads a 16-bit data register if it intends to write. It then writes a select register that names the channel, the word and the direction. That write starts an access, which the block carries out against an internal synchronous RAM over several clock cycles. The host polls the busy bit of the select register until it reads 0. After a read, the fetched word is waiting in the data register.

The same RAM is shared with an on-chip DMA engine through a word-wide side port, and that port always wins a cycle in which both sides want the memory. Of the six words per channel, the host may write only the lower half of dword 2. The upper half of dword 2 carries the DMA engine's 13-bit byte count (largest value 8188) and its 3-bit buffer-threshold count (0 to 7), and the host may only read it. An attempt to write any read-only word, or any access that uses an unused word code, finishes normally but leaves the RAM untouched and raises a sticky error output.

Both host registers use plain write strobes with always-valid read data, so there is no back-pressure on the host side. The host throttles itself by polling busy, and any strobe that arrives during an access is dropped. The DMA port is a plain request port with no stall: a request is served in the cycle it is made.

Top module: `chan_cfg_indirect`

## Requirements
- R1: After reset, the select register reads 0x0000, so busy (bit 15) is 0, and the error output is 0.
- R2: A select write accepted while idle stores the channel in bits 7:0, the word code in bits 10:8 and the direction in bit 14 (1 = read, 0 = write). These fields read back unchanged, and busy reads 1 from the next cycle.
- R3: If the DMA port makes no request, busy stays 1 for exactly two cycles after the accepting clock edge. Each cycle of DMA request while the access waits for the RAM adds one cycle.
- R4: A read with word code w in 0..5 (0/1 = low/high half of dword 0, 2/3 of dword 1, 4/5 of dword 2) on channel c leaves RAM word c*6+w in the data register by the time busy reads 0.
- R5: A write with word code 4 (low half of dword 2) stores the data register into that word of the selected channel.
- R6: A write with any word code other than 4 leaves the RAM unchanged, completes with the normal busy timing and sets the error output.
- R7: Word codes 6 and 7 are illegal. A read or write that uses them leaves the RAM and the data register unchanged, completes with the normal busy timing and sets the error output.
- R8: A select write while busy is 1 is ignored, and the fields of the access in flight keep their values.
- R9: A data-register write while busy is 1 is ignored.
- R10: A DMA-side read returns the addressed word on the DMA read-data output one cycle after the request. A DMA-side write takes effect at once.
- R11: Once set, the error output stays 1 through later legal accesses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_wr | input | 1 | Select-register write strobe |
| host_sel_wdata | input | 16 | Select-register write value |
| host_sel_rdata | output | 16 | Select-register read value, including busy |
| host_dat_wr | input | 1 | Data-register write strobe |
| host_dat_wdata | input | 16 | Data-register write value |
| host_dat_rdata | output | 16 | Data-register read value |
| acc_err | output | 1 | Sticky error from a protected or illegal access |
| dma_req | input | 1 | DMA-side RAM request, has priority |
| dma_we | input | 1 | DMA-side write enable |
| dma_chan | input | 8 | DMA-side channel index |
| dma_word | input | 3 | DMA-side word code 0..5 |
| dma_wdata | input | 16 | DMA-side write data |
| dma_rdata | output | 16 | DMA-side read data, valid one cycle after a read request |

## Verification
Busy shows its first 1 in the cycle after the select strobe's edge. Without DMA traffic it shows 0 in the third cycle after that edge, and each DMA request cycle during the wait shifts that point by one. The bench counts busy-high cycles at falling edges, so it can compare the exact total to 2, or to 2 plus the number of stall cycles. Data register, select readback and error flag are checked only after busy has dropped. A DMA read is sampled at the falling edge that follows its request edge, which is where the one-cycle RAM latency places the data.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;
  localparam int REG_W    = 16;
  localparam int RW_BIT   = 14;
  localparam int BUSY_BIT = 15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RDWAIT,
    ST_DONE
  } acc_state_e;
endpackage

// File: rtl/chcfg_ram.sv
module chcfg_ram #(
  parameter int DEPTH  = 1536,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/chcfg_arb.sv
module chcfg_arb #(
  parameter int CHAN_W    = 8,
  parameter int SEL_W     = 3,
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 6,
  parameter int ADDR_W    = 11
) (
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [CHAN_W-1:0] dma_chan,
  input  logic [SEL_W-1:0]  dma_word,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [CHAN_W-1:0] host_chan,
  input  logic [SEL_W-1:0]  host_word,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_gnt,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(NUM_WORDS);

  logic [CHAN_W-1:0] chan_mux;
  logic [SEL_W-1:0]  word_mux;

  assign host_gnt  = host_req && !dma_req;
  assign ram_en    = dma_req || host_req;
  assign ram_we    = dma_req ? dma_we : host_we;
  assign ram_wdata = dma_req ? dma_wdata : host_wdata;
  assign chan_mux  = dma_req ? dma_chan : host_chan;
  assign word_mux  = dma_req ? dma_word : host_word;
  assign ram_addr  = ADDR_W'(chan_mux) * STRIDE + ADDR_W'(word_mux);
endmodule

// File: rtl/chcfg_seq.sv
module chcfg_seq
  import chcfg_pkg::*;
#(
  parameter int CHAN_W       = 8,
  parameter int SEL_W        = 3,
  parameter int DATA_W       = 16,
  parameter int NUM_WORDS    = 6,
  parameter int HOST_WR_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [REG_W-1:0]  sel_wdata,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [REG_W-1:0]  sel_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              err,
  output logic              req,
  output logic              we,
  output logic [CHAN_W-1:0] chan,
  output logic [SEL_W-1:0]  word,
  input  logic              gnt,
  input  logic [DATA_W-1:0] ram_q
);
  localparam logic [SEL_W-1:0] WR_CODE = SEL_W'(HOST_WR_CODE);

  acc_state_e        state;
  logic              rd_dir;
  logic [DATA_W-1:0] dat_q;
  logic              busy;
  logic              code_legal;
  logic              op_ok;

  assign busy       = (state != ST_IDLE);
  assign code_legal = (int'(word) < NUM_WORDS);
  assign op_ok      = code_legal && (rd_dir || (word == WR_CODE));
  assign req        = (state == ST_REQ) && op_ok;
  assign we         = !rd_dir;
  assign dat_rdata  = dat_q;

  always_comb begin
    sel_rdata                 = '0;
    sel_rdata[CHAN_W-1:0]     = chan;
    sel_rdata[CHAN_W +: SEL_W] = word;
    sel_rdata[RW_BIT]         = rd_dir;
    sel_rdata[BUSY_BIT]       = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      chan   <= '0;
      word   <= '0;
      rd_dir <= 1'b0;
      dat_q  <= '0;
      err    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (dat_wr) dat_q <= dat_wdata;
          if (sel_wr) begin
            chan   <= sel_wdata[CHAN_W-1:0];
            word   <= sel_wdata[CHAN_W +: SEL_W];
            rd_dir <= sel_wdata[RW_BIT];
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (!op_ok) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end else if (gnt) begin
            state <= rd_dir ? ST_RDWAIT : ST_DONE;
          end
        end
        ST_RDWAIT: begin
          dat_q <= ram_q;
          state <= ST_IDLE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chan_cfg_indirect.sv
module chan_cfg_indirect
  import chcfg_pkg::*;
#(
  parameter int CHANNELS     = 256,
  parameter int NUM_WORDS    = 6,
  parameter int SEL_W        = 3,
  parameter int DATA_W       = 16,
  parameter int HOST_WR_CODE = 4,
  localparam int CHAN_W = $clog2(CHANNELS),
  localparam int DEPTH  = CHANNELS * NUM_WORDS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel_wr,
  input  logic [REG_W-1:0]  host_sel_wdata,
  output logic [REG_W-1:0]  host_sel_rdata,
  input  logic              host_dat_wr,
  input  logic [DATA_W-1:0] host_dat_wdata,
  output logic [DATA_W-1:0] host_dat_rdata,
  output logic              acc_err,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [CHAN_W-1:0] dma_chan,
  input  logic [SEL_W-1:0]  dma_word,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata
);
  logic              h_req, h_we, h_gnt;
  logic [CHAN_W-1:0] h_chan;
  logic [SEL_W-1:0]  h_word;
  logic              r_en, r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, r_q;

  chcfg_seq #(
    .CHAN_W(CHAN_W), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .NUM_WORDS(NUM_WORDS), .HOST_WR_CODE(HOST_WR_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(host_sel_wr), .sel_wdata(host_sel_wdata),
    .dat_wr(host_dat_wr), .dat_wdata(host_dat_wdata),
    .sel_rdata(host_sel_rdata), .dat_rdata(host_dat_rdata),
    .err(acc_err), .req(h_req), .we(h_we),
    .chan(h_chan), .word(h_word), .gnt(h_gnt), .ram_q(r_q)
  );

  chcfg_arb #(
    .CHAN_W(CHAN_W), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
  ) u_arb (
    .dma_req(dma_req), .dma_we(dma_we), .dma_chan(dma_chan),
    .dma_word(dma_word), .dma_wdata(dma_wdata),
    .host_req(h_req), .host_we(h_we), .host_chan(h_chan),
    .host_word(h_word), .host_wdata(host_dat_rdata),
    .host_gnt(h_gnt), .ram_en(r_en), .ram_we(r_we),
    .ram_addr(r_addr), .ram_wdata(r_wdata)
  );

  chcfg_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(r_en), .we(r_we), .addr(r_addr),
    .wdata(r_wdata), .q(r_q)
  );

  assign dma_rdata = r_q;
endmodule

// File: rtl/chan_cfg_indirect_chk.sv
module chan_cfg_indirect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel_wr,
  input logic        host_dat_wr,
  input logic [15:0] host_sel_rdata,
  input logic [15:0] host_dat_rdata,
  input logic        acc_err
);
  logic busy;
  assign busy = host_sel_rdata[15];

  a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel_wr && !busy) |=> busy);

  a_r3_busy_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  a_r8_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel_wr && busy) |=> (host_sel_rdata[14:0] == $past(host_sel_rdata[14:0])));

  a_r9_dat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_wr && busy && !host_sel_rdata[14]) |=> $stable(host_dat_rdata));

  a_r6_err_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> busy);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);
endmodule

bind chan_cfg_indirect chan_cfg_indirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel_wr(host_sel_wr),
  .host_dat_wr(host_dat_wr), .host_sel_rdata(host_sel_rdata),
  .host_dat_rdata(host_dat_rdata), .acc_err(acc_err)
);

// File: tb/chan_cfg_indirect_test.sv
module chan_cfg_indirect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel_wr = 1'b0;
  logic [15:0] host_sel_wdata = '0;
  logic [15:0] host_sel_rdata;
  logic        host_dat_wr = 1'b0;
  logic [15:0] host_dat_wdata = '0;
  logic [15:0] host_dat_rdata;
  logic        acc_err;
  logic        dma_req = 1'b0;
  logic        dma_we = 1'b0;
  logic [7:0]  dma_chan = '0;
  logic [2:0]  dma_word = '0;
  logic [15:0] dma_wdata = '0;
  logic [15:0] dma_rdata;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;

  chan_cfg_indirect uut (.*);

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [7:0] c, input logic [2:0] w);
    return {c, 8'h00} ^ {13'h0, w} ^ 16'h5A30;
  endfunction

  function automatic logic [15:0] mk_sel(input logic rd, input logic [2:0] w, input logic [7:0] c);
    return {1'b0, rd, 3'b000, w, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic dma_wr(input logic [7:0] c, input logic [2:0] w, input logic [15:0] d);
    @(negedge clk);
    dma_req = 1'b1; dma_we = 1'b1; dma_chan = c; dma_word = w; dma_wdata = d;
    @(negedge clk);
    dma_req = 1'b0; dma_we = 1'b0;
  endtask

  task automatic dma_rd(input logic [7:0] c, input logic [2:0] w, output logic [15:0] d);
    @(negedge clk);
    dma_req = 1'b1; dma_we = 1'b0; dma_chan = c; dma_word = w;
    @(negedge clk);
    dma_req = 1'b0;
    d = dma_rdata;
  endtask

  task automatic dat_write(input logic [15:0] d);
    @(negedge clk);
    host_dat_wr = 1'b1; host_dat_wdata = d;
    @(negedge clk);
    host_dat_wr = 1'b0;
  endtask

  // Issue a select write and count falling edges that see busy high.
  task automatic access(input logic rd, input logic [2:0] w, input logic [7:0] c, output int cyc);
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(rd, w, c);
    @(negedge clk);
    host_sel_wr = 1'b0;
    cyc = 0;
    while (host_sel_rdata[15] && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_sel_rdata == 16'h0000, "R1 select", 32'(host_sel_rdata), 32'h0);
    chk(acc_err == 1'b0, "R1 err", 32'(acc_err), 32'h0);
  endtask

  task automatic t_preload_and_dma;
    logic [15:0] d;
    foreach (pre_ch[i])
      for (int w = 0; w < 6; w++) dma_wr(pre_ch[i], 3'(w), pat(pre_ch[i], 3'(w)));
    dma_rd(8'd127, 3'd3, d);
    chk(d == pat(8'd127, 3'd3), "R10 dma read", 32'(d), 32'(pat(8'd127, 3'd3)));
  endtask

  task automatic t_reads;
    int cyc;
    foreach (pre_ch[i])
      for (int w = 0; w < 6; w++) begin
        access(1'b1, 3'(w), pre_ch[i], cyc);
        chk(host_dat_rdata == pat(pre_ch[i], 3'(w)), "R4 read data",
            32'(host_dat_rdata), 32'(pat(pre_ch[i], 3'(w))));
        chk(cyc == 2, "R3 busy cycles", 32'(cyc), 32'd2);
        chk(host_sel_rdata == mk_sel(1'b1, 3'(w), pre_ch[i]), "R2 fields",
            32'(host_sel_rdata), 32'(mk_sel(1'b1, 3'(w), pre_ch[i])));
      end
    chk(acc_err == 1'b0, "R6 no err on legal", 32'(acc_err), 32'h0);
  endtask

  task automatic t_busy_visible;
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(1'b1, 3'd0, 8'd1);
    @(negedge clk);
    host_sel_wr = 1'b0;
    chk(host_sel_rdata[15] == 1'b1, "R2 busy set", 32'(host_sel_rdata[15]), 32'h1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_host_write;
    int cyc;
    logic [15:0] d;
    dat_write(16'hBEEF);
    access(1'b0, 3'd4, 8'd255, cyc);
    chk(cyc == 2, "R3 write busy", 32'(cyc), 32'd2);
    dma_rd(8'd255, 3'd4, d);
    chk(d == 16'hBEEF, "R5 stored", 32'(d), 32'hBEEF);
    dma_rd(8'd255, 3'd5, d);
    chk(d == pat(8'd255, 3'd5), "R5 neighbour", 32'(d), 32'(pat(8'd255, 3'd5)));
  endtask

  task automatic t_dma_stall;
    int cyc;
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(1'b1, 3'd2, 8'd0);
    @(negedge clk);
    host_sel_wr = 1'b0;
    dma_req = 1'b1; dma_we = 1'b0; dma_chan = 8'd1; dma_word = 3'd1;
    cyc = 0;
    while (host_sel_rdata[15] && cyc < 50) begin
      cyc++;
      if (cyc == 4) dma_req = 1'b0;
      @(negedge clk);
    end
    dma_req = 1'b0;
    chk(cyc == 5, "R3 stall busy", 32'(cyc), 32'd5);
    chk(host_dat_rdata == pat(8'd0, 3'd2), "R10 host after dma", 32'(host_dat_rdata),
        32'(pat(8'd0, 3'd2)));
  endtask

  task automatic t_ignore_while_busy;
    int cyc;
    logic [15:0] d;
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(1'b1, 3'd1, 8'd1);
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(1'b0, 3'd4, 8'd127);
    host_dat_wr = 1'b1; host_dat_wdata = 16'h1234;
    @(negedge clk);
    host_sel_wr = 1'b0; host_dat_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_sel_rdata == mk_sel(1'b1, 3'd1, 8'd1), "R8 select kept",
        32'(host_sel_rdata), 32'(mk_sel(1'b1, 3'd1, 8'd1)));
    chk(host_dat_rdata == pat(8'd1, 3'd1), "R8 read result", 32'(host_dat_rdata),
        32'(pat(8'd1, 3'd1)));
    dat_write(16'hC0DE);
    @(negedge clk);
    host_sel_wr = 1'b1; host_sel_wdata = mk_sel(1'b0, 3'd4, 8'd0);
    @(negedge clk);
    host_sel_wr = 1'b0;
    host_dat_wr = 1'b1; host_dat_wdata = 16'h7777;
    @(negedge clk);
    host_dat_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_dat_rdata == 16'hC0DE, "R9 data kept", 32'(host_dat_rdata), 32'hC0DE);
    dma_rd(8'd0, 3'd4, d);
    chk(d == 16'hC0DE, "R9 written value", 32'(d), 32'hC0DE);
  endtask

  task automatic t_protected;
    int cyc;
    logic [15:0] d;
    dat_write(16'hDEAD);
    access(1'b0, 3'd5, 8'd127, cyc);
    chk(cyc == 2, "R6 busy", 32'(cyc), 32'd2);
    chk(acc_err == 1'b1, "R6 err", 32'(acc_err), 32'h1);
    dma_rd(8'd127, 3'd5, d);
    chk(d == pat(8'd127, 3'd5), "R6 ram kept", 32'(d), 32'(pat(8'd127, 3'd5)));
    access(1'b0, 3'd0, 8'd127, cyc);
    dma_rd(8'd127, 3'd0, d);
    chk(d == pat(8'd127, 3'd0), "R6 word0 kept", 32'(d), 32'(pat(8'd127, 3'd0)));
    access(1'b1, 3'd3, 8'd1, cyc);
    chk(acc_err == 1'b1, "R11 sticky", 32'(acc_err), 32'h1);
  endtask

  task automatic t_illegal;
    int cyc;
    logic [15:0] d;
    dat_write(16'h4444);
    access(1'b1, 3'd6, 8'd1, cyc);
    chk(cyc == 2, "R7 read busy", 32'(cyc), 32'd2);
    chk(acc_err == 1'b1, "R7 read err", 32'(acc_err), 32'h1);
    chk(host_dat_rdata == 16'h4444, "R7 data kept", 32'(host_dat_rdata), 32'h4444);
    access(1'b0, 3'd7, 8'd0, cyc);
    chk(cyc == 2, "R7 write busy", 32'(cyc), 32'd2);
    dma_rd(8'd1, 3'd0, d);
    chk(d == pat(8'd1, 3'd0), "R7 next chan kept", 32'(d), 32'(pat(8'd1, 3'd0)));
    dma_rd(8'd1, 3'd1, d);
    chk(d == pat(8'd1, 3'd1), "R7 next chan kept", 32'(d), 32'(pat(8'd1, 3'd1)));
  endtask

  logic [7:0] pre_ch [4] = '{8'd0, 8'd1, 8'd127, 8'd255};

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_preload_and_dma;
    t_reads;
    t_busy_visible;
    t_host_write;
    t_dma_stall;
    t_ignore_while_busy;
    t_protected;
    t_illegal;
    t_reset;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule